// File: doc/BRIEF.md
# Burst Column Sequencer with Data Mask Timing

This block sits beside the command path of a synchronous DRAM controller model. It decodes the current mode word into four settings: burst length, wrap order, read latency and the single-beat write option. When a read or write command arrives, it produces one column address per beat of the burst. It marks each beat as a read or a write and flags the beats whose data is masked. For every read beat it also raises a data-valid strobe that trails the beat by the programmed latency. The storage array, the rows and the per-bank state are not part of this block.

A command loads the start column and takes a snapshot of the decoded settings. From the next cycle the block emits one beat per cycle. The burst ends when it reaches its length, when a new read or write command arrives, or when a stop (precharge) is seen. Full-page bursts keep wrapping through all 512 columns until one of the last two events ends them. If the mode word holds a reserved code, the error output rises and the block falls back to single-beat bursts with a latency of two.

Top module: `burst_col_unit`

## Requirements
- R1: Burst length comes from mode bits [2:0]: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives full page (sequential wrap only).
- R2: Mode bit 3 picks the wrap order, with 0 for sequential and 1 for interleave. With length L, beat k of a sequential burst keeps the start column's upper bits and puts (start+k) mod L in the low log2(L) bits. Beat k of an interleaved burst is start XOR k.
- R3: Read latency comes from mode bits [6:4]: 001 gives 1, 010 gives 2, 011 gives 3. `rd_data_vld` is high exactly latency cycles after each cycle that shows a read beat.
- R4: When mode bit 9 is 1, every write burst is a single beat. Reads still use the programmed length.
- R5: A full-page burst steps through all 512 columns in sequence and wraps from 511 to 0. It goes on until a new command or a stop ends it.
- R6: Beat 0 appears in the cycle after the command edge. One beat follows per cycle, with `beat_wr` high for write bursts.
- R7: Write latency is zero. `beat_mask` on a write beat equals `dqm` as sampled at the edge that captures that beat's data: the command edge for beat 0, then one edge per beat. This is the value of `dqm` in the cycle before the beat is shown.
- R8: `rd_data_mask` in a cycle with `rd_data_vld` equals `dqm` as it was two cycles earlier. It is low whenever `rd_data_vld` is low.
- R9: A new read or write command, or `cmd_stop`, ends the current burst at that edge. No beat of the old burst follows. Read data for beats already shown still comes out.
- R10: A reserved burst-length code, full page with interleave, or a reserved latency code raises `cfg_err` in the same cycle. Commands under such a word produce 1-beat bursts with a latency of 2.
- R11: Out of reset there are no beats and no read-data strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_word | input | 10 | Current mode word |
| cmd_rd | input | 1 | Read command (wins over write) |
| cmd_wr | input | 1 | Write command |
| cmd_stop | input | 1 | Precharge/terminate, ends the burst |
| start_col | input | 9 | Start column of the command |
| dqm | input | 1 | Data mask input |
| beat_vld | output | 1 | A beat is shown this cycle |
| beat_wr | output | 1 | Shown beat belongs to a write |
| beat_col | output | 9 | Column of the shown beat |
| beat_mask | output | 1 | Write beat data is masked |
| rd_data_vld | output | 1 | Read data is due this cycle |
| rd_data_mask | output | 1 | Due read data is masked |
| cfg_err | output | 1 | Mode word holds a reserved code |

## Verification
Beat k of a command issued in cycle c is due in cycle c+1+k. Its read data is due in cycle c+1+k+latency, carrying the mask driven in cycle c+k+latency-1, while a write beat carries the mask driven in cycle c+k. The driver stamps each expected item with its cycle number and queues it. The monitor samples on the falling edge and compares the stamp against a free-running cycle count, so an early, late or missing result fails. Each command is followed by enough idle cycles for in-flight read data to drain before the next latency snapshot.

// File: rtl/burst_col_unit.sv
module burst_col_unit #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [9:0]       mode_word,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_stop,
  input  logic [COL_W-1:0] start_col,
  input  logic             dqm,
  output logic             beat_vld,
  output logic             beat_wr,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_mask,
  output logic             rd_data_vld,
  output logic             rd_data_mask,
  output logic             cfg_err
);
  logic [2:0] len_code, lat_code;
  logic ilv_sel, len_bad, lat_bad, full_dec, go, go_wr, wone;
  logic [COL_W-1:0] m_dec;
  logic [1:0] lat_dec;

  assign len_code = mode_word[2:0];
  assign ilv_sel  = mode_word[3];
  assign lat_code = mode_word[6:4];
  assign len_bad  = (len_code[2] && len_code != 3'b111) || (len_code == 3'b111 && ilv_sel);
  assign lat_bad  = (lat_code == 3'b000) || lat_code[2];
  assign cfg_err  = len_bad || lat_bad;
  assign full_dec = !cfg_err && len_code == 3'b111;
  assign lat_dec  = cfg_err ? 2'd2 : lat_code[1:0];
  assign go       = cmd_rd || cmd_wr;
  assign go_wr    = cmd_wr && !cmd_rd;
  assign wone     = go_wr && mode_word[9];

  always_comb begin
    m_dec = '0;
    if (!cfg_err)
      case (len_code)
        3'd1:    m_dec = COL_W'(1);
        3'd2:    m_dec = COL_W'(3);
        3'd3:    m_dec = COL_W'(7);
        3'd7:    m_dec = '1;
        default: m_dec = '0;
      endcase
  end

  logic             act, wr_q, ilv_q, full_q, wone_q, dq1, dq2;
  logic [COL_W-1:0] base, cnt, m_q;
  logic [1:0]       lat_q;
  logic [2:0]       rp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; wr_q <= 1'b0; ilv_q <= 1'b0; full_q <= 1'b0; wone_q <= 1'b0;
      base <= '0; cnt <= '0; m_q <= '0; lat_q <= 2'd2;
      dq1 <= 1'b0; dq2 <= 1'b0; rp <= '0;
    end else begin
      dq1 <= dqm;
      dq2 <= dq1;
      rp  <= {rp[1:0], act && !wr_q};
      if (go) begin
        act    <= 1'b1;
        wr_q   <= go_wr;
        base   <= start_col;
        cnt    <= '0;
        m_q    <= wone ? '0 : m_dec;
        full_q <= full_dec && !wone;
        ilv_q  <= ilv_sel;
        lat_q  <= lat_dec;
        wone_q <= wone;
      end else if (cmd_stop) begin
        act <= 1'b0;
      end else if (act) begin
        if (cnt == m_q && !full_q) act <= 1'b0;
        else cnt <= cnt + 1'b1;
      end
    end
  end

  assign beat_vld     = act;
  assign beat_wr      = wr_q;
  assign beat_col     = ilv_q ? (base ^ (cnt & m_q)) : ((base & ~m_q) | ((base + cnt) & m_q));
  assign beat_mask    = act && wr_q && dq1;
  assign rd_data_vld  = (lat_q == 2'd1) ? rp[0] : (lat_q == 2'd2) ? rp[1] : rp[2];
  assign rd_data_mask = rd_data_vld && dq2;

  // R2
  in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act && !full_q |-> ((beat_col ^ base) & ~m_q) == '0);
  // R3
  rd_lat2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_vld && lat_q == 2'd2 && $past(lat_q) == 2'd2 && $past(lat_q, 2) == 2'd2
    |-> $past(act && !wr_q, 2));
  // R4
  single_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld && beat_wr && wone_q && !cmd_rd && !cmd_wr |=> !beat_vld);
  // R9
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop && !cmd_rd && !cmd_wr |=> !beat_vld);
  // R10
  err_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd && cfg_err |=> beat_vld ##1 (!beat_vld || $past(cmd_rd || cmd_wr)));
endmodule

// File: tb/test_burst_col_unit.sv
module test_burst_col_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] mode_word = '0;
  logic cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_stop = 1'b0, dqm = 1'b0;
  logic [8:0] start_col = '0;
  logic beat_vld, beat_wr, beat_mask, rd_data_vld, rd_data_mask, cfg_err;
  logic [8:0] beat_col;

  burst_col_unit i_burst_col_unit (.*);

  always #4 clk = ~clk;

  int cyc = 0, tests = 0, fails = 0;
  bit mon_on = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int cyc; logic wr; logic mask; logic [8:0] col; } beat_t;
  typedef struct { int cyc; logic mask; } rd_t;
  beat_t bq[$];
  rd_t   rq[$];

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  function automatic void dec(input logic [9:0] mw, output int len, output int lat,
                              output bit ilv, output bit err);
    logic [2:0] b, c;
    b = mw[2:0]; c = mw[6:4]; ilv = mw[3];
    err = 1'b0;
    case (b)
      3'd0: len = 1; 3'd1: len = 2; 3'd2: len = 4; 3'd3: len = 8;
      3'd7: begin len = 0; if (ilv) err = 1'b1; end
      default: begin len = 1; err = 1'b1; end
    endcase
    if (c >= 3'd1 && c <= 3'd3) lat = int'(c); else begin lat = 2; err = 1'b1; end
    if (err) begin len = 1; lat = 2; end
  endfunction

  task automatic go(input bit is_wr, input logic [8:0] s, input int ncyc,
                    input bit stop, input int tail, input logic [31:0] pat);
    int len, lat, nb, c0;
    bit ilv, err;
    logic [8:0] m, kk;
    dec(mode_word, len, lat, ilv, err);
    if (is_wr && mode_word[9]) len = 1;
    nb = (len == 0 || len > ncyc) ? ncyc : len;
    m  = (len == 0) ? 9'h1FF : 9'(len - 1);
    c0 = cyc;
    for (int k = 0; k < nb; k++) begin
      beat_t b;
      kk = 9'(k);
      b.cyc = c0 + 1 + k;
      b.wr  = is_wr;
      b.mask = is_wr ? pat[k % 32] : 1'b0;
      b.col = ilv ? (s ^ (kk & m)) : ((s & ~m) | ((s + kk) & m));
      bq.push_back(b);
      if (!is_wr) begin
        rd_t r;
        r.cyc = c0 + 1 + k + lat;
        r.mask = pat[(k + lat - 1) % 32];
        rq.push_back(r);
      end
    end
    for (int j = 0; j < ncyc + tail; j++) begin
      cmd_rd    = (j == 0) && !is_wr;
      cmd_wr    = (j == 0) && is_wr;
      cmd_stop  = stop && (j == ncyc);
      dqm       = pat[j % 32];
      start_col = s;
      if (j == 0) begin
        #1;
        chk(cfg_err == err, "R10 cfg_err", int'(cfg_err), int'(err));
      end
      @(negedge clk);
    end
    cmd_rd = 1'b0; cmd_wr = 1'b0; cmd_stop = 1'b0;
  endtask

  always @(negedge clk) if (mon_on) begin
    if (bq.size() > 0 && bq[0].cyc < cyc) begin
      chk(1'b0, "R6 missing beat", 0, bq[0].cyc);
      void'(bq.pop_front());
    end
    if (beat_vld) begin
      if (bq.size() == 0) chk(1'b0, "R9 unexpected beat", int'(beat_col), -1);
      else begin
        beat_t e;
        e = bq.pop_front();
        chk(e.cyc == cyc, "R6 beat cycle", cyc, e.cyc);
        chk({beat_wr, beat_mask, beat_col} == {e.wr, e.mask, e.col},
            "R1 R2 R4 R5 R7 beat wr/mask/col", int'({beat_wr, beat_mask, beat_col}),
            int'({e.wr, e.mask, e.col}));
      end
    end
    if (rq.size() > 0 && rq[0].cyc < cyc) begin
      chk(1'b0, "R3 missing read data", 0, rq[0].cyc);
      void'(rq.pop_front());
    end
    if (rd_data_vld) begin
      if (rq.size() == 0) chk(1'b0, "R3 unexpected read data", cyc, -1);
      else begin
        rd_t e;
        e = rq.pop_front();
        chk(e.cyc == cyc, "R3 read data cycle", cyc, e.cyc);
        chk(rd_data_mask == e.mask, "R8 read mask", int'(rd_data_mask), int'(e.mask));
      end
    end else if (rd_data_mask) chk(1'b0, "R8 mask without data", 1, 0);
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!beat_vld && !rd_data_vld, "R11 reset outputs", int'({beat_vld, rd_data_vld}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!beat_vld && !rd_data_vld, "R11 after reset", int'({beat_vld, rd_data_vld}), 0);
    mon_on = 1'b1;
    mode_word = 10'h022; go(1'b0, 9'h1FE, 8, 1'b0, 4, 32'hA5A5_3C3C);
    mode_word = 10'h03B; go(1'b0, 9'h0A5, 10, 1'b0, 4, 32'h1234_5678);
    mode_word = 10'h011; go(1'b1, 9'h07F, 4, 1'b0, 2, 32'h0000_0001);
                         go(1'b0, 9'h07F, 4, 1'b0, 4, 32'h0000_0006);
    mode_word = 10'h03A; go(1'b1, 9'h0C6, 6, 1'b0, 2, 32'h0000_000A);
    mode_word = 10'h223; go(1'b1, 9'h155, 10, 1'b0, 2, 32'hFFFF_FFFF);
                         go(1'b0, 9'h155, 10, 1'b0, 4, 32'h0F0F_0F0F);
    mode_word = 10'h027; go(1'b0, 9'h1F0, 520, 1'b1, 4, 32'h9C3A_51E7);
    mode_word = 10'h023; go(1'b1, 9'h010, 3, 1'b0, 0, 32'h0000_0002);
                         go(1'b0, 9'h020, 10, 1'b0, 4, 32'h0000_0050);
                         go(1'b0, 9'h030, 3, 1'b1, 4, 32'h0000_0015);
    mode_word = 10'h025; go(1'b0, 9'h044, 4, 1'b0, 4, 32'h0000_000F);
    mode_word = 10'h02F; go(1'b0, 9'h100, 4, 1'b0, 4, 32'h0000_0003);
    mode_word = 10'h002; go(1'b0, 9'h0E1, 4, 1'b0, 4, 32'h0000_0004);
    mode_word = 10'h042; go(1'b1, 9'h0E1, 4, 1'b0, 4, 32'h0000_0001);
    repeat (6) @(negedge clk);
    chk(bq.size() == 0, "R6 all beats seen", bq.size(), 0);
    chk(rq.size() == 0, "R3 all read data seen", rq.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule